// File: doc/BRIEF.md
# Tiny 8-bit Multicycle CPU Core

This block is a small accumulator-free 8-bit processor with four general registers, a program counter, a stack pointer and two unsigned compare flags (less-than and equal). Code and data share one internal 256-byte single-port RAM. A host fills that RAM through a byte-wide load port while the core is held in reset. When reset is released, execution starts at address 0.

Instructions are one or two bytes long. Each one passes through a fetch step, an optional operand step and an execute step. At most one RAM access happens per clock. The core emits register values on a strobed output port and keeps an architectural cycle tally. A timed-pause instruction hands its operand byte to an external delay timer and stalls until the timer answers. A return made with an empty stack stops the core, and so does any byte that decodes to nothing. Once stopped, the core raises `halted` and stays there until the next reset.

Top module: `mc8_core`

## Requirements
- R1: While and after reset, `halted`, `out_valid`, `tmr_start` and `cycle_count` are 0. PC starts at 0, SP at 255, and all registers and both flags are 0.
- R2: MOV immediate (`111000rr`, imm) and MOV register (`0101ddss`) copy the value. OUT (`111100rr`) drives the register on `out_data` with `out_valid` high for exactly one clock.
- R3: SUB immediate (`000100rr`, imm) and SUB register (`1101ddss`) store Rd minus operand modulo 256 and leave both flags untouched.
- R4: CMP immediate (`100100rr`, imm) and CMP register (`0011ddss`) set LT when Rd < operand, treating both as unsigned, and EQ when they are equal, and change no register. JMP `0x40`, JEQ `0x20` and JLT `0xC0` take a target byte. JEQ and JLT branch only when their flag is 1.
- R5: PUSH (`101000rr`) writes RAM[SP] and then decrements SP. POP (`011000rr`) increments SP and then reads RAM[SP]. POP on an empty stack (SP=255) yields 0 and keeps SP.
- R6: CALL `0x00`, target pushes the address just after its two bytes and jumps. RET `0x80` pops that address into PC.
- R7: RET with SP=255 halts the core. `halted` then stays high, the count freezes and no further output appears.
- R8: LDR (`1011ddss`, base) loads Rd from RAM[(base+Rs) mod 256]. STR (`0111ddss`, base) writes Rd there.
- R9: A byte that matches no encoding (for example `0xFF`) halts the core and adds 1 to the count.
- R10: `cycle_count` grows by 1 per one-byte instruction, 2 per two-byte instruction and 3 per LDR or STR.
- R11: Pause `0xF8`, value raises `tmr_start` with `value` on `tmr_value`. Both hold until `tmr_done`, and no later instruction runs before it. A done in the same cycle as the first start is honoured.
- R12: The load port writes RAM only while `rst_n` is low. Writes made with reset released are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also enables loading |
| load_en | input | 1 | RAM write strobe for the load port |
| load_addr | input | 8 | Load address |
| load_data | input | 8 | Load byte |
| tmr_done | input | 1 | Delay timer finished |
| out_data | output | 8 | Value emitted by OUT |
| out_valid | output | 1 | One-clock strobe for out_data |
| halted | output | 1 | Core has stopped |
| cycle_count | output | CNT_W (32) | Architectural cycle tally |
| tmr_start | output | 1 | Delay request, held until done |
| tmr_value | output | 8 | Pause operand forwarded to the timer |

## Verification
The case where two events land in the same clock is the timer handshake: the core's start request and the timer's done answer. The bench timer model has a programmable latency. With latency 0, done is asserted combinationally in the very cycle that start first rises. With latency 5, done comes after a stall. In both runs the bench counts the start-high cycles and expects latency plus one. It checks that the operand byte stays on the value port for the whole request, and that the OUT which follows the pause still appears with its value and the correct cycle tally.

// File: rtl/mc8_pkg.sv
package mc8_pkg;

    typedef enum logic [4:0] {
        OP_CALL, OP_JMP, OP_JEQ, OP_JLT, OP_RET,
        OP_PUSH, OP_POP, OP_OUT,
        OP_MOVI, OP_SUBI, OP_CMPI,
        OP_MOVR, OP_SUBR, OP_CMPR,
        OP_LDR, OP_STR, OP_TIM, OP_BAD
    } op_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_OPND, ST_EXEC, ST_WAIT, ST_HALT
    } state_e;

endpackage

// File: rtl/mc8_ram.sv
module mc8_ram #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/mc8_decode.sv
module mc8_decode
    import mc8_pkg::*;
(
    input  logic [7:0] code,
    output op_e        op,
    output logic       two_byte,
    output logic [1:0] rd,
    output logic [1:0] rs
);
    always_comb begin
        op       = OP_BAD;
        two_byte = 1'b0;
        rd       = code[1:0];
        rs       = code[1:0];
        casez (code)
            8'h00:        begin op = OP_CALL; two_byte = 1'b1; end
            8'h40:        begin op = OP_JMP;  two_byte = 1'b1; end
            8'h20:        begin op = OP_JEQ;  two_byte = 1'b1; end
            8'hC0:        begin op = OP_JLT;  two_byte = 1'b1; end
            8'h80:        op = OP_RET;
            8'hF8:        begin op = OP_TIM;  two_byte = 1'b1; end
            8'b101000??:  op = OP_PUSH;
            8'b011000??:  op = OP_POP;
            8'b111100??:  op = OP_OUT;
            8'b111000??:  begin op = OP_MOVI; two_byte = 1'b1; end
            8'b000100??:  begin op = OP_SUBI; two_byte = 1'b1; end
            8'b100100??:  begin op = OP_CMPI; two_byte = 1'b1; end
            8'b0101????:  begin op = OP_MOVR; rd = code[3:2]; end
            8'b1101????:  begin op = OP_SUBR; rd = code[3:2]; end
            8'b0011????:  begin op = OP_CMPR; rd = code[3:2]; end
            8'b1011????:  begin op = OP_LDR;  rd = code[3:2]; two_byte = 1'b1; end
            8'b0111????:  begin op = OP_STR;  rd = code[3:2]; two_byte = 1'b1; end
            default:      op = OP_BAD;
        endcase
    end

endmodule

// File: rtl/mc8_alu.sv
module mc8_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] diff,
    output logic          lt,
    output logic          eq
);
    always_comb begin
        diff = a - b;
        lt   = (a < b);
        eq   = (a == b);
    end

endmodule

// File: rtl/mc8_core.sv
module mc8_core
    import mc8_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NREG  = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [DW-1:0]    load_addr,
    input  logic [DW-1:0]    load_data,
    input  logic             tmr_done,
    output logic [DW-1:0]    out_data,
    output logic             out_valid,
    output logic             halted,
    output logic [CNT_W-1:0] cycle_count,
    output logic             tmr_start,
    output logic [DW-1:0]    tmr_value
);
    localparam int          AW     = DW;
    localparam logic [AW-1:0] SP_TOP = {AW{1'b1}};

    typedef struct packed {
        state_e                    st;
        logic [AW-1:0]             pc;
        logic [AW-1:0]             sp;
        logic [NREG-1:0][DW-1:0]   regs;
        logic                      lt;
        logic                      eq;
        logic [DW-1:0]             ir;
        logic [DW-1:0]             opnd;
        logic [CNT_W-1:0]          cnt;
        logic                      ov;
        logic [DW-1:0]             od;
    } core_t;

    core_t q, d;

    // memory port
    logic          mem_we, core_we;
    logic [AW-1:0] mem_addr, core_addr;
    logic [DW-1:0] mem_wdata, core_wdata, mem_rdata;

    // decode and alu
    logic [DW-1:0] dec_in;
    op_e           dec_op;
    logic          dec_two;
    logic [1:0]    dec_rd, dec_rs;
    logic [DW-1:0] alu_a, alu_b, alu_diff;
    logic          alu_lt, alu_eq;
    logic [1:0]    cost;

    assign mem_we    = rst_n ? core_we    : load_en;
    assign mem_addr  = rst_n ? core_addr  : load_addr;
    assign mem_wdata = rst_n ? core_wdata : load_data;

    mc8_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign dec_in = (q.st == ST_FETCH) ? mem_rdata : q.ir;

    mc8_decode u_dec (
        .code     (dec_in),
        .op       (dec_op),
        .two_byte (dec_two),
        .rd       (dec_rd),
        .rs       (dec_rs)
    );

    assign alu_a = q.regs[dec_rd];
    assign alu_b = dec_two ? q.opnd : q.regs[dec_rs];

    mc8_alu #(.DW(DW)) u_alu (
        .a    (alu_a),
        .b    (alu_b),
        .diff (alu_diff),
        .lt   (alu_lt),
        .eq   (alu_eq)
    );

    always_comb begin
        d          = q;
        d.ov       = 1'b0;
        core_we    = 1'b0;
        core_addr  = q.pc;
        core_wdata = '0;
        cost       = 2'd0;
        unique case (q.st)
            ST_FETCH: begin
                d.ir = mem_rdata;
                d.pc = q.pc + 1'b1;
                if (dec_op == OP_BAD) begin
                    d.st = ST_HALT;
                    cost = 2'd1;
                end else if (dec_two) begin
                    d.st = ST_OPND;
                end else begin
                    d.st = ST_EXEC;
                end
            end
            ST_OPND: begin
                d.opnd = mem_rdata;
                d.pc   = q.pc + 1'b1;
                d.st   = ST_EXEC;
            end
            ST_EXEC: begin
                d.st = ST_FETCH;
                if (dec_op == OP_LDR || dec_op == OP_STR) cost = 2'd3;
                else if (dec_two)                          cost = 2'd2;
                else                                       cost = 2'd1;
                case (dec_op)
                    OP_CALL: begin
                        core_addr  = q.sp;
                        core_we    = 1'b1;
                        core_wdata = q.pc;
                        d.sp       = q.sp - 1'b1;
                        d.pc       = q.opnd;
                    end
                    OP_JMP: d.pc = q.opnd;
                    OP_JEQ: if (q.eq) d.pc = q.opnd;
                    OP_JLT: if (q.lt) d.pc = q.opnd;
                    OP_RET: begin
                        if (q.sp == SP_TOP) begin
                            d.st = ST_HALT;
                        end else begin
                            core_addr = q.sp + 1'b1;
                            d.sp      = q.sp + 1'b1;
                            d.pc      = mem_rdata;
                        end
                    end
                    OP_PUSH: begin
                        core_addr  = q.sp;
                        core_we    = 1'b1;
                        core_wdata = q.regs[dec_rd];
                        d.sp       = q.sp - 1'b1;
                    end
                    OP_POP: begin
                        if (q.sp == SP_TOP) begin
                            d.regs[dec_rd] = '0;
                        end else begin
                            core_addr      = q.sp + 1'b1;
                            d.sp           = q.sp + 1'b1;
                            d.regs[dec_rd] = mem_rdata;
                        end
                    end
                    OP_OUT: begin
                        d.ov = 1'b1;
                        d.od = q.regs[dec_rd];
                    end
                    OP_MOVI: d.regs[dec_rd] = q.opnd;
                    OP_MOVR: d.regs[dec_rd] = q.regs[dec_rs];
                    OP_SUBI, OP_SUBR: d.regs[dec_rd] = alu_diff;
                    OP_CMPI, OP_CMPR: begin
                        d.lt = alu_lt;
                        d.eq = alu_eq;
                    end
                    OP_LDR: begin
                        core_addr      = q.opnd + q.regs[dec_rs];
                        d.regs[dec_rd] = mem_rdata;
                    end
                    OP_STR: begin
                        core_addr  = q.opnd + q.regs[dec_rs];
                        core_we    = 1'b1;
                        core_wdata = q.regs[dec_rd];
                    end
                    OP_TIM:  d.st = ST_WAIT;
                    default: d.st = ST_HALT;
                endcase
            end
            ST_WAIT: begin
                if (tmr_done) d.st = ST_FETCH;
            end
            default: d.st = ST_HALT;
        endcase
        d.cnt = q.cnt + CNT_W'(cost);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_FETCH;
            q.pc   <= '0;
            q.sp   <= SP_TOP;
            q.regs <= '0;
            q.lt   <= 1'b0;
            q.eq   <= 1'b0;
            q.ir   <= '0;
            q.opnd <= '0;
            q.cnt  <= '0;
            q.ov   <= 1'b0;
            q.od   <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_data    = q.od;
    assign out_valid   = q.ov;
    assign halted      = (q.st == ST_HALT);
    assign cycle_count = q.cnt;
    assign tmr_start   = (q.st == ST_WAIT);
    assign tmr_value   = q.opnd;

    // R2
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !out_valid && $stable(cycle_count)));

    // R11
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_start && !tmr_done) |=> (tmr_start && $stable(tmr_value)));

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cycle_count - $past(cycle_count)) <= CNT_W'(3)));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXEC && dec_op == OP_POP && q.sp == SP_TOP) |=> (q.sp == SP_TOP));

    // R9
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH && dec_op == OP_BAD) |=> halted);

endmodule

// File: tb/sim_mc8_core.sv
`timescale 1ns/1ps
module sim_mc8_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [7:0]  load_data = '0;
    logic        tmr_done;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        halted;
    logic [31:0] cycle_count;
    logic        tmr_start;
    logic [7:0]  tmr_value;

    always #2.5 clk = ~clk;

    mc8_core u0 (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .tmr_done(tmr_done), .out_data(out_data),
        .out_valid(out_valid), .halted(halted), .cycle_count(cycle_count),
        .tmr_start(tmr_start), .tmr_value(tmr_value)
    );

    // delay timer model with programmable latency
    logic [7:0] t_lat = 8'd0;
    logic [7:0] t_cnt = 8'd0;
    assign tmr_done = tmr_start && (t_cnt == t_lat);
    always @(posedge clk) begin
        if (!tmr_start || tmr_done) t_cnt <= 8'd0;
        else                        t_cnt <= t_cnt + 8'd1;
    end

    int errs = 0;
    int checks = 0;
    logic [7:0] prog [256];
    logic [7:0] cap [32];
    int ncap = 0;
    int vrun = 0;
    int vmax = 0;
    int start_cyc = 0;
    int tv_bad = 0;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (ncap < 32) cap[ncap] = out_data;
            ncap++;
            vrun++;
            if (vrun > vmax) vmax = vrun;
        end else begin
            vrun = 0;
        end
        if (rst_n && tmr_start) begin
            start_cyc++;
            if (tmr_value != 8'h9C) tv_bad++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr_prog();
        for (int i = 0; i < 256; i++) prog[i] = 8'h80;
    endtask

    task automatic load_all();
        rst_n = 1'b0;
        @(negedge clk);
        for (int a = 0; a < 256; a++) begin
            load_en = 1'b1; load_addr = 8'(a); load_data = prog[a];
            @(negedge clk);
        end
        load_en = 1'b0;
    endtask

    task automatic go();
        ncap = 0; vmax = 0; start_cyc = 0; tv_bad = 0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        clr_prog();
        prog[0] = 8'hF0; prog[1] = 8'hF1; prog[2] = 8'hF2; prog[3] = 8'hF3;
        prog[4] = 8'h20; prog[5] = 8'h0A; prog[6] = 8'hC0; prog[7] = 8'h0A;
        prog[8] = 8'h80; prog[10] = 8'hF0; prog[11] = 8'hF0;
        load_all();
        chk("R1 halted in reset", int'(halted), 0);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 count in reset", int'(cycle_count), 0);
        chk("R1 tmr_start in reset", int'(tmr_start), 0);
        go();
        chk("R1 outputs seen", ncap, 4);
        for (int i = 0; i < 4; i++) chk("R1 register zero", int'(cap[i]), 0);
        chk("R7 halted", int'(halted), 1);
        chk("R10 count", int'(cycle_count), 9);
    endtask

    task automatic t_mov();
        clr_prog();
        prog[0] = 8'hE0; prog[1] = 8'h5A; prog[2] = 8'hE3; prog[3] = 8'hFF;
        prog[4] = 8'hF3; prog[5] = 8'h5C; prog[6] = 8'hF3; prog[7] = 8'h51;
        prog[8] = 8'hF0; prog[9] = 8'h80;
        load_all(); go();
        chk("R2 count of OUT", ncap, 3);
        chk("R2 MOV imm", int'(cap[0]), 8'hFF);
        chk("R2 MOV reg", int'(cap[1]), 8'h5A);
        chk("R2 MOV reg zero", int'(cap[2]), 8'h00);
        chk("R2 strobe width", vmax, 1);
        chk("R10 count", int'(cycle_count), 10);
    endtask

    task automatic t_sub();
        clr_prog();
        prog[0] = 8'hE2; prog[1] = 8'h09; prog[2] = 8'h92; prog[3] = 8'h09;
        prog[4] = 8'hE0; prog[5] = 8'h05; prog[6] = 8'h10; prog[7] = 8'h07;
        prog[8] = 8'hF0; prog[9] = 8'hE1; prog[10] = 8'h03; prog[11] = 8'hD1;
        prog[12] = 8'hF0; prog[13] = 8'h20; prog[14] = 8'h10; prog[15] = 8'hF2;
        prog[16] = 8'h80;
        load_all(); go();
        chk("R3 count of OUT", ncap, 2);
        chk("R3 SUB imm wraps", int'(cap[0]), 8'hFE);
        chk("R3 SUB reg", int'(cap[1]), 8'hFB);
        chk("R10 count", int'(cycle_count), 16);
    endtask

    task automatic t_cmp();
        clr_prog();
        prog[0] = 8'hE0; prog[1] = 8'h03; prog[2] = 8'hE1; prog[3] = 8'h07;
        prog[4] = 8'h31; prog[5] = 8'h20; prog[6] = 8'h40; prog[7] = 8'hC0;
        prog[8] = 8'h0A; prog[9] = 8'hF3; prog[10] = 8'hE2; prog[11] = 8'h80;
        prog[12] = 8'h92; prog[13] = 8'h7F; prog[14] = 8'hC0; prog[15] = 8'h40;
        prog[16] = 8'hF2; prog[17] = 8'h92; prog[18] = 8'h80; prog[19] = 8'h20;
        prog[20] = 8'h17; prog[21] = 8'hF0; prog[22] = 8'h80; prog[23] = 8'h40;
        prog[24] = 8'h1A; prog[25] = 8'hF1; prog[26] = 8'h80;
        prog[64] = 8'hF1;
        load_all(); go();
        chk("R4 branch path OUT count", ncap, 1);
        chk("R4 unsigned compare keeps reg", int'(cap[0]), 8'h80);
        chk("R10 count", int'(cycle_count), 23);
    endtask

    task automatic t_stack();
        clr_prog();
        prog[0] = 8'hE0; prog[1] = 8'h11; prog[2] = 8'hE1; prog[3] = 8'h22;
        prog[4] = 8'hA0; prog[5] = 8'hA1; prog[6] = 8'h62; prog[7] = 8'h63;
        prog[8] = 8'hF2; prog[9] = 8'hF3; prog[10] = 8'h61; prog[11] = 8'hF1;
        prog[12] = 8'hE0; prog[13] = 8'h33; prog[14] = 8'hA0; prog[15] = 8'h63;
        prog[16] = 8'hF3; prog[17] = 8'h80;
        load_all(); go();
        chk("R5 count of OUT", ncap, 4);
        chk("R5 LIFO first", int'(cap[0]), 8'h22);
        chk("R5 LIFO second", int'(cap[1]), 8'h11);
        chk("R5 empty pop zero", int'(cap[2]), 8'h00);
        chk("R5 SP kept after empty pop", int'(cap[3]), 8'h33);
        chk("R7 empty RET halts", int'(halted), 1);
        chk("R10 count", int'(cycle_count), 18);
    endtask

    task automatic t_call();
        clr_prog();
        prog[0] = 8'h00; prog[1] = 8'h06; prog[2] = 8'hF0; prog[3] = 8'h80;
        prog[6] = 8'h63; prog[7] = 8'hF3; prog[8] = 8'hA3; prog[9] = 8'hE0;
        prog[10] = 8'h77; prog[11] = 8'h80;
        load_all(); go();
        chk("R6 count of OUT", ncap, 2);
        chk("R6 pushed return address", int'(cap[0]), 8'h02);
        chk("R6 RET resumes after CALL", int'(cap[1]), 8'h77);
        chk("R10 count", int'(cycle_count), 10);
        repeat (10) @(negedge clk);
        chk("R7 halt persists", int'(halted), 1);
        chk("R7 count frozen", int'(cycle_count), 10);
        chk("R7 no further OUT", ncap, 2);
    endtask

    task automatic t_mem();
        clr_prog();
        prog[0] = 8'hE0; prog[1] = 8'hAB; prog[2] = 8'hE1; prog[3] = 8'hF0;
        prog[4] = 8'h71; prog[5] = 8'h20; prog[6] = 8'hBB; prog[7] = 8'h10;
        prog[8] = 8'hF2; prog[9] = 8'hBD; prog[10] = 8'h20; prog[11] = 8'hF3;
        prog[12] = 8'h80; prog[16] = 8'h00;
        load_all(); go();
        chk("R8 count of OUT", ncap, 2);
        chk("R8 STR wrapped, LDR direct", int'(cap[0]), 8'hAB);
        chk("R8 LDR indexed wrap", int'(cap[1]), 8'hAB);
        chk("R10 LDR/STR cost", int'(cycle_count), 16);
    endtask

    task automatic t_bad();
        clr_prog();
        prog[0] = 8'hE0; prog[1] = 8'h42; prog[2] = 8'hF0; prog[3] = 8'hFF;
        prog[4] = 8'hF0;
        load_all(); go();
        chk("R9 halted", int'(halted), 1);
        chk("R9 OUT before bad byte only", ncap, 1);
        chk("R9 value", int'(cap[0]), 8'h42);
        chk("R9 count", int'(cycle_count), 4);
    endtask

    task automatic t_timer(input logic [7:0] lat);
        clr_prog();
        prog[0] = 8'hE0; prog[1] = 8'h01; prog[2] = 8'hF8; prog[3] = 8'h9C;
        prog[4] = 8'hF0; prog[5] = 8'h80;
        t_lat = lat;
        load_all(); go();
        chk("R11 start high cycles", start_cyc, int'(lat) + 1);
        chk("R11 value held", tv_bad, 0);
        chk("R11 OUT after pause", ncap, 1);
        chk("R11 OUT value", int'(cap[0]), 8'h01);
        chk("R10 count", int'(cycle_count), 6);
    endtask

    task automatic t_load_ignored();
        clr_prog();
        prog[0] = 8'hE0; prog[1] = 8'h11; prog[2] = 8'hF0; prog[3] = 8'h80;
        load_all(); go();
        chk("R12 first run", int'(cap[0]), 8'h11);
        for (int i = 0; i < 4; i++) begin
            load_en = 1'b1; load_addr = 8'd1; load_data = 8'h99;
            @(negedge clk);
        end
        load_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        go();
        chk("R12 load without reset ignored", int'(cap[0]), 8'h11);
        chk("R12 out count", ncap, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_mov();
        t_sub();
        t_cmp();
        t_stack();
        t_call();
        t_mem();
        t_bad();
        t_timer(8'd0);
        t_timer(8'd5);
        t_load_ignored();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule